// File: doc/BRIEF.md
# Tick-Based Watchdog Reset Timer

This block is a watchdog whose timeout is counted in ticks of a periodic real-time base, not in raw clock cycles. A free-running prescaler, cleared only by power-on reset, produces a single-cycle tick. A 2-bit select input picks one of four tick periods. A three-bit divide-by-eight stage counts these ticks. On its overflow the block issues a system reset pulse of fixed length, unless software has cleared it first.

Software clears the watchdog by writing a zero into bit 0 of the register at address 0x7F0. This returns the divide-by-eight stage to zero but leaves the prescaler running. The time from a clear to the reset therefore falls between seven and eight tick periods, depending on the prescaler phase at the moment of the write. While the programming-voltage flag input is high, an overflow still occurs but produces no reset.

Top module: `rti_watchdog`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `wdt_rst_o` is 0.
- R2: With `rate_sel_i` = s, a tick occurs every 2^(BASE_LOG2+s) clock cycles. For a prescaler count c since power-on reset, the tick falls on the cycle where c mod period = period-1.
- R3: The eighth tick after the divide-by-eight stage was last zero overflows it back to 0. `wdt_rst_o` goes high on the following cycle. With no clear at all, this is 8 periods after power-on reset.
- R4: A write with `wr_en_i`=1, `wr_addr_i`=0x7F0 and `wr_data_i[0]`=0 returns the divide-by-eight stage to 0. Periodic clears spaced less than 7 periods apart prevent any reset.
- R5: A write to 0x7F0 with bit 0 = 1, or a write to any other address, leaves the watchdog count unchanged.
- R6: When a clear and a tick fall in the same cycle, the clear wins. The reset then comes exactly 8 periods after that clear.
- R7: While `prog_volt_i` is 1, an overflow produces no reset pulse.
- R8: Each reset pulse is high for exactly PULSE_LEN cycles. The overflow that starts it also leaves the count at 0.
- R9: A clear does not move the prescaler. If the next tick is one cycle after the clear, the reset rises 7·period+1 cycles after the clear edge. In every case the delay lies in (7·period, 8·period].
- R10: Only `rst_ni` resets the prescaler. A watchdog reset pulse leaves its phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rate_sel_i | input | 2 | Tick period select |
| prog_volt_i | input | 1 | Interrupt pin at programming voltage; blocks the reset |
| wdt_rst_o | output | 1 | Watchdog system reset pulse |

## Verification
A clear write presented in one cycle takes effect at the next edge. The tick of a cycle and an overflow in it show on `wdt_rst_o` one edge later. The pulse then lasts PULSE_LEN cycles. The bench drives inputs on the falling edge and keeps a behavioural model updated on the rising edge. It compares `wdt_rst_o` against that model at every falling edge. Directed checks count rising edges from the clear edge to the first falling edge that sees the reset high. They place clears at chosen prescaler phases, so the expected counts of 8·period and 7·period+1 are exact.

// File: rtl/rti_wdt_pkg.sv
package rti_wdt_pkg;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned NUM_RATES = 1 << SEL_W;
  localparam int unsigned DIV_W     = 3;  // divide-by-eight stage
endpackage

// File: rtl/rti_prescaler.sv
module rti_prescaler
  import rti_wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = BASE_LOG2 + NUM_RATES - 1;

  logic [PRE_W-1:0]     cnt_q;
  logic [NUM_RATES-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_tap
    assign tap[r] = &cnt_q[BASE_LOG2+r-1:0];
  end

  assign tick_o = tap[rate_sel_i];

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || rate_sel_i != $past(rate_sel_i))); // R2
endmodule

// File: rtl/cop_clear_decode.sv
module cop_clear_decode #(
  parameter int unsigned          ADDR_W   = 11,
  parameter int unsigned          DATA_W   = 8,
  parameter logic [ADDR_W-1:0]    CLR_ADDR = 11'h7F0,
  parameter int unsigned          CLR_BIT  = 0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              clr_o
);
  assign clr_o = wr_en_i && (wr_addr_i == CLR_ADDR) && !wr_data_i[CLR_BIT];

  always_comb begin
    if (wr_en_i && wr_data_i[CLR_BIT]) AST_ONE_NO_CLEAR: assert (!clr_o); // R5
  end
endmodule

// File: rtl/cop_core.sv
module cop_core
  import rti_wdt_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic prog_volt_i,
  output logic wdt_rst_o
);
  localparam int unsigned PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [PULSE_W-1:0] PULSE_INIT = PULSE_W'(PULSE_LEN);

  logic [DIV_W-1:0]   div_q;
  logic [PULSE_W-1:0] pulse_q;
  logic               ovf;

  assign ovf = tick_i && !clr_i && (&div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;  // clear beats a coincident tick
    else if (tick_i) div_q <= div_q + 1'b1;  // overflow wraps to zero
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pulse_q <= '0;
    else if (ovf && !prog_volt_i) pulse_q <= PULSE_INIT;
    else if (pulse_q != '0)       pulse_q <= pulse_q - 1'b1;
  end

  assign wdt_rst_o = (pulse_q != '0);

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0)); // R4
  AST_CLR_BEATS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && tick_i && div_q != '0) |=> (div_q == '0)); // R6
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && div_q == '1) |=> (div_q == '0)); // R8
  AST_OVF_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !prog_volt_i) |=> wdt_rst_o); // R3
  AST_PROG_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_volt_i && !wdt_rst_o) |=> !wdt_rst_o); // R7
endmodule

// File: rtl/rti_watchdog.sv
module rti_watchdog
  import rti_wdt_pkg::*;
#(
  parameter int unsigned       BASE_LOG2 = 14,
  parameter int unsigned       PULSE_LEN = 4,
  parameter int unsigned       ADDR_W    = 11,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 11'h7F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rate_sel_i,
  input  logic              prog_volt_i,
  output logic              wdt_rst_o
);
  logic tick, clr;

  rti_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk_i, .rst_ni, .rate_sel_i, .tick_o(tick)
  );

  cop_clear_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_ADDR(CLR_ADDR), .CLR_BIT(0)
  ) u_dec (
    .wr_en_i, .wr_addr_i, .wr_data_i, .clr_o(clr)
  );

  cop_core #(.PULSE_LEN(PULSE_LEN)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(clr), .prog_volt_i, .wdt_rst_o
  );

  AST_RST_LOW: assert property (@(posedge clk_i) $rose(rst_ni) |-> !wdt_rst_o); // R1
endmodule

// File: tb/sim_rti_watchdog.sv
`timescale 1ns/1ps
module sim_rti_watchdog;
  localparam int BASE = 4;
  localparam int PLEN = 4;
  localparam int PRE_MOD = 1 << (BASE + 3);

  logic clk = 0, rst_ni = 0, wr_en = 0, prog = 0;
  logic [10:0] addr = '0;
  logic [7:0]  data = '0;
  logic [1:0]  sel = '0;
  logic        wdt_rst;

  int checks = 0, errors = 0;
  int m_presc = 0, m_div = 0, m_pulse = 0;

  always #2 clk = ~clk;  // 250 MHz

  rti_watchdog #(.BASE_LOG2(BASE), .PULSE_LEN(PLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_data_i(data), .rate_sel_i(sel), .prog_volt_i(prog), .wdt_rst_o(wdt_rst)
  );

  function automatic int per();
    return 1 << (BASE + int'(sel));
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_presc = 0; m_div = 0; m_pulse = 0;
    end else begin
      bit tk, cl, ov;
      tk = (m_presc % per()) == per() - 1;
      cl = wr_en && addr == 11'h7F0 && !data[0];
      ov = tk && !cl && m_div == 7;
      if (cl) m_div = 0; else if (tk) m_div = (m_div + 1) % 8;
      if (ov && !prog) m_pulse = PLEN; else if (m_pulse > 0) m_pulse--;
      m_presc = (m_presc + 1) % PRE_MOD;
    end
  end

  always @(negedge clk) if (rst_ni) begin
    checks++;
    if (wdt_rst !== (m_pulse != 0)) begin
      errors++;
      $display("FAIL R3 per-cycle model at %0t actual=%0b expected=%0b", $time, wdt_rst, m_pulse != 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_low();
    while (wdt_rst) @(negedge clk);
  endtask

  task automatic wait_phase(input int ph);
    while ((m_presc % per()) != ph) @(negedge clk);
  endtask

  // clear at this negedge, count edges until reset is seen high
  task automatic measure(input bit bad, output int k);
    wr_en = 1; addr = 11'h7F0; data = 8'hFE;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    k = 0;
    while (!wdt_rst && k < 5000) begin
      if (bad && k % 10 == 3) begin
        wr_en = 1;
        if ((k / 10) % 2 == 0) begin addr = 11'h7F0; data = 8'h01; end
        else begin addr = 11'h7F1; data = 8'h00; end
      end else wr_en = 0;
      @(posedge clk); k++; @(negedge clk);
    end
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, n;
    repeat (3) @(negedge clk);
    chk(wdt_rst == 0, "R1 reset state", wdt_rst, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(wdt_rst == 0, "R1 after release", wdt_rst, 0);

    // R3: no clear, reset at 8 periods from power-on
    k = 1;
    while (!wdt_rst && k < 5000) begin @(posedge clk); k++; @(negedge clk); end
    chk(k == 8 * 16, "R3 timeout from POR", k, 128);
    n = 0;
    while (wdt_rst) begin n++; @(negedge clk); end
    chk(n == PLEN, "R8 pulse width", n, PLEN);

    // R10: prescaler phase kept across the pulse; R9 earliest timeout
    wait_phase(per() - 2);
    measure(0, k);
    chk(k == 7 * 16 + 1, "R10 prescaler kept after pulse", k, 113);
    wait_low();
    repeat (5) @(negedge clk);
    measure(0, k);
    chk(k > 7 * 16 && k <= 8 * 16, "R9 timeout window", k, 120);

    // R6 clear coincides with tick
    wait_low(); wait_phase(per() - 1);
    measure(0, k);
    chk(k == 8 * 16, "R6 clear beats tick", k, 128);

    // R2 other rates
    for (int s = 1; s < 4; s++) begin
      wait_low(); sel = 2'(s);
      wait_phase(per() - 1);
      measure(0, k);
      chk(k == 8 * per(), "R2 rate period", k, 8 * per());
    end
    sel = 0;

    // R5 ignored writes
    wait_low(); wait_phase(per() - 1);
    measure(1, k);
    chk(k == 8 * 16, "R5 ignored writes", k, 128);

    // R4 periodic clears hold off reset
    wait_low();
    n = 0;
    for (int i = 0; i < 10; i++) begin
      wr_en = 1; addr = 11'h7F0; data = 8'h00;
      @(negedge clk); wr_en = 0;
      repeat (99) begin @(negedge clk); if (wdt_rst) n++; end
    end
    chk(n == 0, "R4 clears prevent reset", n, 0);

    // R7 programming voltage blocks reset
    prog = 1;
    n = 0;
    repeat (300) begin @(negedge clk); if (wdt_rst) n++; end
    chk(n == 0, "R7 reset suppressed", n, 0);
    prog = 0;
    n = 0;
    repeat (140) begin @(negedge clk); if (wdt_rst) n++; end
    chk(n == PLEN, "R7 reset resumes", n, PLEN);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule